// File: doc/BRIEF.md
# Control-Register Hazard Spacing Monitor

This block observes an in-order stream of decoded instructions, at most one per clock when the valid input is high. It checks that every instruction that depends on a system-control side effect comes far enough behind the instruction that produced that effect. The producing instructions are translation-table writes, reads and probes, tag loads, moves to control registers, and stores. Each producer arms a saturating distance counter. Each consumer checks the relevant counter against a minimum spacing. That spacing is derived from pipeline stages as ready stage minus (use stage plus one).

The outputs are combinational in the cycle of the offending instruction. `violation` flags the problem, `hazardCode` names the hazard, and `stallSlots` gives the number of further instructions that would have been needed. A pipeline can use these as a stall request or as a debug trap. The monitor never holds the stream back. A redirect (exception or taken branch) drops every pending hazard.

Top module: `cp_hazard_monitor`

## Requirements
- R1: After reset, `violation`, `hazardCode` and `stallSlots` are 0, and no tracker is armed, so any first instruction raises nothing.
- R2: Spacing is the number of valid instructions strictly between producer and consumer, and cycles with `instValid` low neither count nor raise a flag. A consumer with spacing below the minimum raises `violation`. Class codes are: 0 other, 1 load, 2 store, 3 cache op, 4 index tag load, 5 table write, 6 table read, 7 table probe, 8 move-to-control, 9 move-from-control, 10 exception return, 11 coprocessor op, 12 interrupt-enable dependent.
- R3: After a table write, a probe needs 3 (code 1), a load or store needs 3 (code 2), and any instruction with `instMapFetch` high needs 5 (code 3).
- R4: A move-to-control of register 12 needs 3 before an exception return (code 10). With `instField[0]` set it also needs 4 before a coprocessor op (code 4). With `instField[1]` set it also needs 3 before an interrupt-enable dependent instruction (code 11).
- R5: A table read needs 3 before a move-from-control of register 10 (code 5). A probe needs 2 before a move-from-control of register 0 (code 7). A tag load needs 1 before a move-from-control of register 28 (code 13).
- R6: A move-to-control of register 2 needs 1 before a table write (code 6). Register 10 needs 1 before a probe (code 8). Register 14 needs 2 before an exception return (code 9).
- R7: A move-from-control right after a move-to-control of the same register number raises code 12. A different register number raises nothing.
- R8: A cache op or tag load to the same `instLine` as the last store needs 2 separators after the store (code 14). Loads, cache ops and tag loads are not separators. A different line raises nothing.
- R9: When several hazards fire together, `hazardCode` is the one with the largest remaining distance. On a tie, the lower code wins.
- R10: `stallSlots` equals the required distance minus the actual spacing of the reported hazard, saturated at 7. It is 0 and `hazardCode` is 0 when `violation` is low.
- R11: In a cycle with `redirect` high no violation is raised, the instruction in that cycle is discarded, and every tracker is cleared.
- R12: An instruction that raises a violation still acts as a producer and as a separator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | An instruction issues this cycle |
| instClass | input | 4 | Instruction class code (R2) |
| instReg | input | REG_W | Control register number |
| instField | input | 2 | Status field selector: bit 0 usable bits, bit 1 interrupt enable |
| instLine | input | LINE_W | Primary cache line index |
| instMapFetch | input | 1 | Instruction fetch uses a freshly written mapping |
| redirect | input | 1 | Exception or branch redirect, clears all trackers |
| violation | output | 1 | Spacing violation this cycle |
| hazardCode | output | 4 | Reported hazard code, 0 when none |
| stallSlots | output | STALL_W | Missing instruction slots, saturated |

## Verification
A tracker counter stuck or stepping wrongly shows up at the first consumer after its producer. The flag then appears or vanishes at the wrong gap, and the stall count is off by the counter error. For this reason every producer-consumer pair is swept over every gap from 0 to 6, which pins each counter's value at each step. A wrong store line or register capture shows at once as a missed or spurious code 14 or 12. A faulty redirect clear shows on the very next consumer. A broken priority shows as the wrong code when two hazards coincide.

// File: rtl/cphz_pkg.sv
`timescale 1ns/1ps
package cphz_pkg;

  typedef enum logic [3:0] {
    CLS_OTHER    = 4'd0,
    CLS_LOAD     = 4'd1,
    CLS_STORE    = 4'd2,
    CLS_CACHE    = 4'd3,
    CLS_TAGLOAD  = 4'd4,
    CLS_TLBWRITE = 4'd5,
    CLS_TLBREAD  = 4'd6,
    CLS_TLBPROBE = 4'd7,
    CLS_MOVETO   = 4'd8,
    CLS_MOVEFROM = 4'd9,
    CLS_ERET     = 4'd10,
    CLS_COPOP    = 4'd11,
    CLS_IEDEP    = 4'd12
  } instClass_e;

  // producer trackers
  localparam int TRK_TLBW   = 0;
  localparam int TRK_TLBR   = 1;
  localparam int TRK_TLBP   = 2;
  localparam int TRK_TAGLD  = 3;
  localparam int TRK_ELO0   = 4;
  localparam int TRK_EHI    = 5;
  localparam int TRK_EPC    = 6;
  localparam int TRK_STAT   = 7;
  localparam int TRK_STATCU = 8;
  localparam int TRK_STATIE = 9;
  localparam int TRK_MTC    = 10;
  localparam int TRK_STORE  = 11;
  localparam int NUM_TRK    = 12;

  // hazard index h reports code h+1
  localparam int NUM_HAZ       = 14;
  localparam int HZ_MTC_SAME   = 11;
  localparam int HZ_STORE_LINE = 13;
  localparam int CODE_W        = $clog2(NUM_HAZ + 1);

  typedef struct packed {
    logic                 advance;
    logic                 clearAll;
    logic                 storeSep;
    logic [NUM_TRK-1:0]   arm;
    logic [NUM_HAZ-1:0]   useHit;
  } strobes_t;

  function automatic int hazWriter(input int h);
    case (h)
      0, 1, 2: return TRK_TLBW;
      3:       return TRK_STATCU;
      4:       return TRK_TLBR;
      5:       return TRK_ELO0;
      6:       return TRK_TLBP;
      7:       return TRK_EHI;
      8:       return TRK_EPC;
      9:       return TRK_STAT;
      10:      return TRK_STATIE;
      11:      return TRK_MTC;
      12:      return TRK_TAGLD;
      default: return TRK_STORE;
    endcase
  endfunction

  // stage in which the producer's effect becomes visible
  function automatic int hazReadyStage(input int h);
    case (h)
      0, 1, 2, 4: return 8;
      default:    return 7;
    endcase
  endfunction

  // stage in which the consumer needs the effect
  function automatic int hazUseStage(input int h);
    case (h)
      0, 1, 4:         return 4;
      2, 3:            return 2;
      5, 7, 11, 12:    return 5;
      6, 8, 13:        return 4;
      default:         return 3;
    endcase
  endfunction

  function automatic int hazDist(input int h);
    return hazReadyStage(h) - (hazUseStage(h) + 1);
  endfunction

endpackage

// File: rtl/cphz_ctrl.sv
`timescale 1ns/1ps
module cphz_ctrl
  import cphz_pkg::*;
#(
  parameter int REG_W        = 5,
  parameter int REG_INDEX    = 0,
  parameter int REG_ENTRYLO0 = 2,
  parameter int REG_ENTRYHI  = 10,
  parameter int REG_STATUS   = 12,
  parameter int REG_EPC      = 14,
  parameter int REG_TAGLO    = 28
) (
  input  logic             instValid,
  input  logic [3:0]       instClass,
  input  logic [REG_W-1:0] instReg,
  input  logic [1:0]       instField,
  input  logic             instMapFetch,
  input  logic             redirect,
  output strobes_t         strobes
);

  localparam logic [REG_W-1:0] RegIndex = REG_W'(REG_INDEX);
  localparam logic [REG_W-1:0] RegElo0  = REG_W'(REG_ENTRYLO0);
  localparam logic [REG_W-1:0] RegEhi   = REG_W'(REG_ENTRYHI);
  localparam logic [REG_W-1:0] RegStat  = REG_W'(REG_STATUS);
  localparam logic [REG_W-1:0] RegEpc   = REG_W'(REG_EPC);
  localparam logic [REG_W-1:0] RegTagLo = REG_W'(REG_TAGLO);

  instClass_e cls;
  logic go, isMoveTo, isMoveFrom, isCacheLike, isMem;

  assign cls         = instClass_e'(instClass);
  assign go          = instValid && !redirect;
  assign isMoveTo    = go && (cls == CLS_MOVETO);
  assign isMoveFrom  = go && (cls == CLS_MOVEFROM);
  assign isCacheLike = (cls == CLS_CACHE) || (cls == CLS_TAGLOAD);
  assign isMem       = (cls == CLS_LOAD) || (cls == CLS_STORE);

  always_comb begin
    strobes          = '0;
    strobes.clearAll = redirect;
    strobes.advance  = go;
    strobes.storeSep = go && !isCacheLike && (cls != CLS_LOAD);

    strobes.arm[TRK_TLBW]   = go && (cls == CLS_TLBWRITE);
    strobes.arm[TRK_TLBR]   = go && (cls == CLS_TLBREAD);
    strobes.arm[TRK_TLBP]   = go && (cls == CLS_TLBPROBE);
    strobes.arm[TRK_TAGLD]  = go && (cls == CLS_TAGLOAD);
    strobes.arm[TRK_ELO0]   = isMoveTo && (instReg == RegElo0);
    strobes.arm[TRK_EHI]    = isMoveTo && (instReg == RegEhi);
    strobes.arm[TRK_EPC]    = isMoveTo && (instReg == RegEpc);
    strobes.arm[TRK_STAT]   = isMoveTo && (instReg == RegStat);
    strobes.arm[TRK_STATCU] = isMoveTo && (instReg == RegStat) && instField[0];
    strobes.arm[TRK_STATIE] = isMoveTo && (instReg == RegStat) && instField[1];
    strobes.arm[TRK_MTC]    = isMoveTo;
    strobes.arm[TRK_STORE]  = go && (cls == CLS_STORE);

    strobes.useHit[0]  = go && (cls == CLS_TLBPROBE);
    strobes.useHit[1]  = go && isMem;
    strobes.useHit[2]  = go && instMapFetch;
    strobes.useHit[3]  = go && (cls == CLS_COPOP);
    strobes.useHit[4]  = isMoveFrom && (instReg == RegEhi);
    strobes.useHit[5]  = go && (cls == CLS_TLBWRITE);
    strobes.useHit[6]  = isMoveFrom && (instReg == RegIndex);
    strobes.useHit[7]  = go && (cls == CLS_TLBPROBE);
    strobes.useHit[8]  = go && (cls == CLS_ERET);
    strobes.useHit[9]  = go && (cls == CLS_ERET);
    strobes.useHit[10] = go && (cls == CLS_IEDEP);
    strobes.useHit[11] = isMoveFrom;
    strobes.useHit[12] = isMoveFrom && (instReg == RegTagLo);
    strobes.useHit[13] = go && isCacheLike;
  end

endmodule

// File: rtl/cphz_datapath.sv
`timescale 1ns/1ps
module cphz_datapath
  import cphz_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int LINE_W  = 8,
  parameter int CNT_W   = 3,
  parameter int STALL_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strobes,
  input  logic [REG_W-1:0]   instReg,
  input  logic [LINE_W-1:0]  instLine,
  output logic               violation,
  output logic [CODE_W-1:0]  hazardCode,
  output logic [STALL_W-1:0] stallSlots
);

  localparam logic [CNT_W-1:0] CntMax   = {CNT_W{1'b1}};
  localparam int               StallMax = (1 << STALL_W) - 1;

  logic [NUM_TRK-1:0][CNT_W-1:0] distV;
  logic [REG_W-1:0]              mtcReg;
  logic [LINE_W-1:0]             storeLine;
  logic [NUM_HAZ-1:0]            hit;
  logic [NUM_HAZ-1:0][CNT_W-1:0] remArr;
  logic [CNT_W-1:0]              bestRem;
  logic [CODE_W-1:0]             bestCode;

  // one saturating distance counter per producer; saturated means far away
  for (genvar t = 0; t < NUM_TRK; t++) begin : g_trk
    logic [CNT_W-1:0] cnt;
    logic             stepT;
    if (t == TRK_STORE) begin : g_sep
      assign stepT = strobes.storeSep;
    end else begin : g_all
      assign stepT = strobes.advance;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          cnt <= CntMax;
      else if (strobes.clearAll)          cnt <= CntMax;
      else if (strobes.arm[t])            cnt <= '0;
      else if (stepT && (cnt != CntMax))  cnt <= cnt + 1'b1;
    end
    assign distV[t] = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mtcReg    <= '0;
      storeLine <= '0;
    end else begin
      if (strobes.arm[TRK_MTC])   mtcReg    <= instReg;
      if (strobes.arm[TRK_STORE]) storeLine <= instLine;
    end
  end

  for (genvar h = 0; h < NUM_HAZ; h++) begin : g_haz
    localparam int               WrIdx = hazWriter(h);
    localparam logic [CNT_W-1:0] Need  = CNT_W'(hazDist(h));
    logic qual;
    if (h == HZ_MTC_SAME) begin : g_reg
      assign qual = (mtcReg == instReg);
    end else if (h == HZ_STORE_LINE) begin : g_line
      assign qual = (storeLine == instLine);
    end else begin : g_none
      assign qual = 1'b1;
    end
    assign hit[h]    = strobes.useHit[h] && qual && (distV[WrIdx] < Need);
    assign remArr[h] = hit[h] ? (Need - distV[WrIdx]) : '0;
  end

  // largest remaining distance wins; strict compare keeps the lower code on ties
  always_comb begin
    bestRem  = '0;
    bestCode = '0;
    for (int h = 0; h < NUM_HAZ; h++) begin
      if (hit[h] && (remArr[h] > bestRem)) begin
        bestRem  = remArr[h];
        bestCode = CODE_W'(h + 1);
      end
    end
  end

  assign violation  = |hit;
  assign hazardCode = bestCode;
  assign stallSlots = (32'(bestRem) > StallMax) ? STALL_W'(StallMax)
                                                : STALL_W'(bestRem);

endmodule

// File: rtl/cp_hazard_monitor.sv
`timescale 1ns/1ps
module cp_hazard_monitor
  import cphz_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int LINE_W  = 8,
  parameter int CNT_W   = 3,
  parameter int STALL_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic [3:0]         instClass,
  input  logic [REG_W-1:0]   instReg,
  input  logic [1:0]         instField,
  input  logic [LINE_W-1:0]  instLine,
  input  logic               instMapFetch,
  input  logic               redirect,
  output logic               violation,
  output logic [3:0]         hazardCode,
  output logic [STALL_W-1:0] stallSlots
);

  strobes_t strobes;

  cphz_ctrl #(.REG_W(REG_W)) u_ctrl (
    .instValid    (instValid),
    .instClass    (instClass),
    .instReg      (instReg),
    .instField    (instField),
    .instMapFetch (instMapFetch),
    .redirect     (redirect),
    .strobes      (strobes)
  );

  cphz_datapath #(
    .REG_W(REG_W), .LINE_W(LINE_W), .CNT_W(CNT_W), .STALL_W(STALL_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .instReg    (instReg),
    .instLine   (instLine),
    .violation  (violation),
    .hazardCode (hazardCode),
    .stallSlots (stallSlots)
  );

endmodule

// File: rtl/cp_hazard_monitor_chk.sv
`timescale 1ns/1ps
module cp_hazard_monitor_chk
  import cphz_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int STALL_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               instValid,
  input logic [3:0]         instClass,
  input logic [REG_W-1:0]   instReg,
  input logic               redirect,
  input logic               violation,
  input logic [3:0]         hazardCode,
  input logic [STALL_W-1:0] stallSlots
);

  p_quiet_outputs_r10: assert property (@(posedge clk) disable iff (!rstN)
    !violation |-> (hazardCode == 4'd0) && (stallSlots == '0));

  p_stall_nonzero_r10: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> (stallSlots != '0) && (hazardCode != 4'd0));

  p_invalid_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !violation);

  p_redirect_silent_r11: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> !violation);

  p_redirect_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !violation);

  p_mtc_mfc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !redirect && instClass == CLS_MOVETO) ##1
    (instValid && !redirect && instClass == CLS_MOVEFROM && instReg == $past(instReg))
    |-> violation);

  p_tlbw_probe_r3: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !redirect && instClass == CLS_TLBWRITE) ##1
    (instValid && !redirect && instClass == CLS_TLBPROBE)
    |-> violation && (stallSlots == STALL_W'(3)));

endmodule

bind cp_hazard_monitor cp_hazard_monitor_chk #(.REG_W(REG_W), .STALL_W(STALL_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .instValid  (instValid),
  .instClass  (instClass),
  .instReg    (instReg),
  .redirect   (redirect),
  .violation  (violation),
  .hazardCode (hazardCode),
  .stallSlots (stallSlots)
);

// File: tb/cp_hazard_monitor_test.sv
`timescale 1ns/1ps
module cp_hazard_monitor_test;
  import cphz_pkg::*;

  logic       clk = 1'b0;
  logic       rstN;
  logic       instValid;
  logic [3:0] instClass;
  logic [4:0] instReg;
  logic [1:0] instField;
  logic [7:0] instLine;
  logic       instMapFetch;
  logic       redirect;
  logic       violation;
  logic [3:0] hazardCode;
  logic [2:0] stallSlots;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic       oV;
  logic [3:0] oC;
  logic [2:0] oS;

  always #5 clk = ~clk;

  cp_hazard_monitor uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .instReg(instReg), .instField(instField), .instLine(instLine),
    .instMapFetch(instMapFetch), .redirect(redirect), .violation(violation),
    .hazardCode(hazardCode), .stallSlots(stallSlots)
  );

  // drive right after a falling edge, sample 2 ns later, move to next falling edge
  task automatic drive(input logic v, input logic [3:0] c, input int r,
                       input logic [1:0] f, input int ln, input logic mf,
                       input logic rd);
    instValid = v; instClass = c; instReg = r[4:0]; instField = f;
    instLine = ln[7:0]; instMapFetch = mf; redirect = rd;
    #2;
    oV = violation; oC = hazardCode; oS = stallSlots;
    @(negedge clk);
  endtask

  task automatic issue(input logic [3:0] c, input int r, input logic [1:0] f,
                       input int ln, input logic mf);
    drive(1'b1, c, r, f, ln, mf, 1'b0);
  endtask

  task automatic filler();
    issue(CLS_OTHER, 1, 2'b00, 0, 1'b0);
  endtask

  task automatic flush();
    drive(1'b0, CLS_OTHER, 0, 2'b00, 0, 1'b0, 1'b1);
  endtask

  task automatic expect3(input string tag, input logic eV, input int eC, input int eS);
    checks++;
    if (oV !== eV || oC !== eC[3:0] || oS !== eS[2:0]) begin
      failures++;
      $display("FAIL %s: got viol=%0d code=%0d stall=%0d expected viol=%0d code=%0d stall=%0d",
               tag, oV, oC, oS, eV, eC, eS);
    end
  endtask

  // sweep the gap between a producer and its consumer
  task automatic runPair(input string tag, input int code, input int need,
                         input logic [3:0] wC, input int wR, input logic [1:0] wF, input int wL,
                         input logic [3:0] uC, input int uR, input logic [1:0] uF, input int uL,
                         input logic uM);
    for (int gap = 0; gap <= 6; gap++) begin
      flush();
      issue(wC, wR, wF, wL, 1'b0);
      for (int k = 0; k < gap; k++) filler();
      issue(uC, uR, uF, uL, uM);
      if (gap < need) expect3($sformatf("%s gap=%0d", tag, gap), 1'b1, code, need - gap);
      else            expect3($sformatf("%s gap=%0d", tag, gap), 1'b0, 0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; instValid = 1'b0; instClass = '0; instReg = '0; instField = '0;
    instLine = '0; instMapFetch = 1'b0; redirect = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    oV = violation; oC = hazardCode; oS = stallSlots;
    expect3("R1 outputs in reset", 1'b0, 0, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    issue(CLS_TLBPROBE, 0, 2'b00, 0, 1'b0);
    expect3("R1 probe after reset", 1'b0, 0, 0);
    issue(CLS_MOVEFROM, 10, 2'b00, 0, 1'b1);
    expect3("R1 read and mapped fetch after reset", 1'b0, 0, 0);

    // R3 table write consumers
    runPair("R3 write->probe",    1, 3, CLS_TLBWRITE, 0, 2'b00, 0, CLS_TLBPROBE, 0, 2'b00, 0, 1'b0);
    runPair("R3 write->load",     2, 3, CLS_TLBWRITE, 0, 2'b00, 0, CLS_LOAD,     0, 2'b00, 5, 1'b0);
    runPair("R3 write->store",    2, 3, CLS_TLBWRITE, 0, 2'b00, 0, CLS_STORE,    0, 2'b00, 5, 1'b0);
    runPair("R3 write->fetch",    3, 5, CLS_TLBWRITE, 0, 2'b00, 0, CLS_OTHER,    0, 2'b00, 0, 1'b1);
    // R4 status consumers
    runPair("R4 cu->copop",       4, 4, CLS_MOVETO, 12, 2'b01, 0, CLS_COPOP, 0, 2'b00, 0, 1'b0);
    runPair("R4 status->eret",   10, 3, CLS_MOVETO, 12, 2'b00, 0, CLS_ERET,  0, 2'b00, 0, 1'b0);
    runPair("R4 ie->iedep",      11, 3, CLS_MOVETO, 12, 2'b10, 0, CLS_IEDEP, 0, 2'b00, 0, 1'b0);
    // R5 reads after table ops
    runPair("R5 read->mfc10",     5, 3, CLS_TLBREAD,  0, 2'b00, 0, CLS_MOVEFROM, 10, 2'b00, 0, 1'b0);
    runPair("R5 probe->mfc0",     7, 2, CLS_TLBPROBE, 0, 2'b00, 0, CLS_MOVEFROM,  0, 2'b00, 0, 1'b0);
    runPair("R5 tagload->mfc28", 13, 1, CLS_TAGLOAD,  0, 2'b00, 4, CLS_MOVEFROM, 28, 2'b00, 0, 1'b0);
    // R6 register writes before table ops and return
    runPair("R6 elo0->write",     6, 1, CLS_MOVETO,  2, 2'b00, 0, CLS_TLBWRITE, 0, 2'b00, 0, 1'b0);
    runPair("R6 ehi->probe",      8, 1, CLS_MOVETO, 10, 2'b00, 0, CLS_TLBPROBE, 0, 2'b00, 0, 1'b0);
    runPair("R6 epc->eret",       9, 2, CLS_MOVETO, 14, 2'b00, 0, CLS_ERET,     0, 2'b00, 0, 1'b0);
    // R7 same register back to back
    runPair("R7 mtc5->mfc5",     12, 1, CLS_MOVETO,  5, 2'b00, 0, CLS_MOVEFROM, 5, 2'b00, 0, 1'b0);
    flush(); issue(CLS_MOVETO, 5, 2'b00, 0, 1'b0); issue(CLS_MOVEFROM, 6, 2'b00, 0, 1'b0);
    expect3("R7 different register", 1'b0, 0, 0);
    // R8 store to cache line
    runPair("R8 store->cache",   14, 2, CLS_STORE, 0, 2'b00, 9, CLS_CACHE,   0, 2'b00, 9, 1'b0);
    runPair("R8 store->tagload", 14, 2, CLS_STORE, 0, 2'b00, 9, CLS_TAGLOAD, 0, 2'b00, 9, 1'b0);
    flush(); issue(CLS_STORE, 0, 2'b00, 3, 1'b0);
    issue(CLS_LOAD, 0, 2'b00, 7, 1'b0); issue(CLS_LOAD, 0, 2'b00, 7, 1'b0);
    issue(CLS_CACHE, 0, 2'b00, 3, 1'b0);
    expect3("R8 loads are not separators", 1'b1, 14, 2);
    flush(); issue(CLS_STORE, 0, 2'b00, 3, 1'b0);
    issue(CLS_CACHE, 0, 2'b00, 4, 1'b0);
    expect3("R8 other line", 1'b0, 0, 0);
    issue(CLS_CACHE, 0, 2'b00, 3, 1'b0);
    expect3("R8 cache op not a separator", 1'b1, 14, 2);
    flush(); issue(CLS_STORE, 0, 2'b00, 3, 1'b0);
    filler(); issue(CLS_LOAD, 0, 2'b00, 1, 1'b0); filler();
    issue(CLS_CACHE, 0, 2'b00, 3, 1'b0);
    expect3("R8 two separators around a load", 1'b0, 0, 0);
    // R2 bubbles do not count
    flush(); issue(CLS_TLBWRITE, 0, 2'b00, 0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, CLS_TLBPROBE, 0, 2'b00, 0, 1'b0, 1'b0);
      expect3("R2 invalid cycle silent", 1'b0, 0, 0);
    end
    issue(CLS_TLBPROBE, 0, 2'b00, 0, 1'b0);
    expect3("R2 bubbles not counted", 1'b1, 1, 3);
    // R9 priority
    flush(); issue(CLS_TLBWRITE, 0, 2'b00, 0, 1'b0);
    issue(CLS_LOAD, 0, 2'b00, 0, 1'b1);
    expect3("R9 largest remaining", 1'b1, 3, 5);
    flush(); issue(CLS_TLBWRITE, 0, 2'b00, 0, 1'b0); filler();
    issue(CLS_MOVETO, 10, 2'b00, 0, 1'b0);
    issue(CLS_TLBPROBE, 0, 2'b00, 0, 1'b0);
    expect3("R9 tie goes to lower code", 1'b1, 1, 1);
    flush(); issue(CLS_TLBWRITE, 0, 2'b00, 0, 1'b0);
    issue(CLS_MOVETO, 10, 2'b00, 0, 1'b0);
    issue(CLS_TLBPROBE, 0, 2'b00, 0, 1'b0);
    expect3("R9 R10 larger of two", 1'b1, 1, 2);
    // R11 redirect
    flush(); issue(CLS_TLBWRITE, 0, 2'b00, 0, 1'b0);
    drive(1'b1, CLS_TLBPROBE, 0, 2'b00, 0, 1'b0, 1'b1);
    expect3("R11 redirect cycle silent", 1'b0, 0, 0);
    issue(CLS_TLBPROBE, 0, 2'b00, 0, 1'b0);
    expect3("R11 trackers cleared", 1'b0, 0, 0);
    flush(); drive(1'b1, CLS_TLBWRITE, 0, 2'b00, 0, 1'b0, 1'b1);
    issue(CLS_TLBPROBE, 0, 2'b00, 0, 1'b0);
    expect3("R11 redirected producer discarded", 1'b0, 0, 0);
    // R12 violating instruction still produces
    flush(); issue(CLS_MOVETO, 10, 2'b00, 0, 1'b0);
    issue(CLS_TLBPROBE, 0, 2'b00, 0, 1'b0);
    expect3("R12 probe violates", 1'b1, 8, 1);
    issue(CLS_MOVEFROM, 0, 2'b00, 0, 1'b0);
    expect3("R12 violating probe armed", 1'b1, 7, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule